// File: doc/BRIEF.md
# CPU Bus Address Decoder with Mirrored Work RAM

This block sits on a 16-bit processor address bus with byte-wide data. A small on-chip work RAM answers the lowest 8 KiB of the address space. Only 2 KiB of storage is present, so the low eleven address bits select the byte and the same storage appears four times across the window. Every address above that window is forwarded in the same cycle to a group of external register ports. Each port answers with a claim bit and a read byte.

Read data is registered and appears one cycle after the read strobe. A read that no port claims returns zero. A write that no port claims has no effect. If several ports claim the same access, the lowest-numbered port supplies the data and a sticky conflict flag is raised.

A hard reset, either from the chip reset or from a dedicated request, sweeps zeros through the whole RAM. The sweep takes one cycle per word, and the busy output is high for its full length. A soft reset clears the conflict flag and the read register, but leaves the RAM contents intact.

Top module: `cpu_bus_decoder`

## Requirements
- R1: Addresses 0x0000 to 0x1FFF select the work RAM at index cpu_addr[10:0], so addresses that differ only in bits [12:11] reach the same byte.
- R2: An access above 0x1FFF, made while not busy, raises per_req in the same cycle. per_addr and per_wdata equal the bus values, per_we equals cpu_we, and the RAM is not written.
- R3: cpu_rdata shows the result of a read in the cycle after the read strobe and holds it until the next read.
- R4: A read above 0x1FFF for which per_claim is all zero returns 0x00.
- R5: A write above 0x1FFF that no port claims changes no RAM byte.
- R6: When two or more bits of per_claim are set during a forwarded access, the read returns the data of the lowest-numbered claiming port and conflict_err goes high one cycle later. conflict_err then stays high until rst_n is low or soft_rst is high.
- R7: A low rst_n or a one-cycle hard_rst pulse starts a clearing sweep. After a hard_rst pulse, busy is high for exactly 2048 cycles, and afterwards every RAM byte reads 0x00.
- R8: soft_rst leaves RAM contents unchanged, clears conflict_err, and does not start a sweep.
- R9: While busy is high, accesses are ignored: per_req stays low and reads return 0x00.
- R10: A forwarded read claimed by exactly one port returns that port's byte from per_rdata, where port i occupies bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, starts a clearing sweep |
| hard_rst | input | 1 | Request to clear the RAM with a sweep |
| soft_rst | input | 1 | Clears the conflict flag and read register, keeps the RAM |
| cpu_req | input | 1 | Bus access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| busy | output | 1 | Clearing sweep in progress |
| conflict_err | output | 1 | Sticky multiple-claim flag |
| per_req | output | 1 | Forwarded access strobe |
| per_we | output | 1 | Forwarded write enable |
| per_addr | output | 16 | Forwarded address |
| per_wdata | output | 8 | Forwarded write data |
| per_claim | input | 4 | Claim bit per external port |
| per_rdata | input | 32 | Read bytes of the external ports, port 0 in the low byte |

## Verification
The bench writes through one mirror alias and reads back through the other three, and it reads the top word of the window. A decoder that used too many index bits would return zero instead of the stored byte. An unclaimed write is aimed at an address whose low bits alias a written RAM byte, which catches a decoder that lets external writes reach the RAM. A read claimed by two ports checks both the port priority and the conflict flag, so a highest-wins mux or a flag that is not sticky shows up as a wrong byte or a dropped flag. The sweep length after a hard reset is counted cycle by cycle, and accesses are made during the sweep, so an off-by-one end of sweep or a bus that leaks through while busy is reported.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_RAM  = 2'd1,
      SRC_PORT = 2'd2
   } rd_src_e;
endpackage

// File: rtl/ram_sweeper.sv
module ram_sweeper #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hard_rst,
   output logic          busy,
   output logic [AW-1:0] clr_addr
);
   logic [AW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n || hard_rst) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == {AW{1'b1}}) busy_q <= 1'b0;
      end
   end

   assign busy     = busy_q;
   assign clr_addr = cnt_q;
endmodule

// File: rtl/work_ram.sv
module work_ram #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/periph_arbiter.sv
module periph_arbiter #(
   parameter int NPORT = 4,
   parameter int DW    = 8
) (
   input  logic [NPORT-1:0]    claim,
   input  logic [NPORT*DW-1:0] rdata_bus,
   output logic                any_claim,
   output logic                multi_claim,
   output logic [DW-1:0]       sel_data
);
   logic [DW-1:0] slice [NPORT];

   for (genvar g = 0; g < NPORT; g++) begin : g_slice
      assign slice[g] = rdata_bus[g*DW +: DW];
   end

   always_comb begin
      sel_data = '0;
      for (int i = NPORT - 1; i >= 0; i--) begin
         if (claim[i]) sel_data = slice[i];
      end
   end

   assign any_claim   = |claim;
   assign multi_claim = |(claim & (claim - 1'b1));
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int RAM_AW = 11,
   parameter int WIN_AW = 13,
   parameter int NPORT  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hard_rst,
   input  logic                     soft_rst,
   input  logic                     cpu_req,
   input  logic                     cpu_we,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [DATA_W-1:0]        cpu_wdata,
   output logic [DATA_W-1:0]        cpu_rdata,
   output logic                     busy,
   output logic                     conflict_err,
   output logic                     per_req,
   output logic                     per_we,
   output logic [ADDR_W-1:0]        per_addr,
   output logic [DATA_W-1:0]        per_wdata,
   input  logic [NPORT-1:0]         per_claim,
   input  logic [NPORT*DATA_W-1:0]  per_rdata
);
   import bus_dec_pkg::*;

   localparam int HI_W = ADDR_W - WIN_AW;

   if (WIN_AW < RAM_AW || WIN_AW >= ADDR_W) begin : g_bad_window
      $error("cpu_bus_decoder: window width must lie between RAM_AW and ADDR_W-1");
   end
   if (NPORT < 1 || DATA_W < 1) begin : g_bad_size
      $error("cpu_bus_decoder: NPORT and DATA_W must be positive");
   end

   logic              sweep_busy;
   logic [RAM_AW-1:0] clr_addr;
   logic              in_ram, acc_ok, ram_we;
   logic [RAM_AW-1:0] ram_waddr;
   logic [DATA_W-1:0] ram_wdata, ram_rd, port_data;
   logic              any_claim, multi_claim;
   rd_src_e           src;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;

   ram_sweeper #(.AW(RAM_AW)) u_sweep (
      .clk      (clk),
      .rst_n    (rst_n),
      .hard_rst (hard_rst),
      .busy     (sweep_busy),
      .clr_addr (clr_addr)
   );

   assign in_ram = (cpu_addr[ADDR_W-1 -: HI_W] == '0);
   assign acc_ok = cpu_req & ~sweep_busy;

   assign ram_we    = sweep_busy | (acc_ok & in_ram & cpu_we);
   assign ram_waddr = sweep_busy ? clr_addr : cpu_addr[RAM_AW-1:0];
   assign ram_wdata = sweep_busy ? '0 : cpu_wdata;

   work_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (cpu_addr[RAM_AW-1:0]),
      .rdata (ram_rd)
   );

   periph_arbiter #(.NPORT(NPORT), .DW(DATA_W)) u_arb (
      .claim       (per_claim),
      .rdata_bus   (per_rdata),
      .any_claim   (any_claim),
      .multi_claim (multi_claim),
      .sel_data    (port_data)
   );

   assign per_req   = acc_ok & ~in_ram;
   assign per_we    = per_req & cpu_we;
   assign per_addr  = cpu_addr;
   assign per_wdata = cpu_wdata;

   always_comb begin
      if (!acc_ok)        src = SRC_ZERO;
      else if (in_ram)    src = SRC_RAM;
      else if (any_claim) src = SRC_PORT;
      else                src = SRC_ZERO;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         rdata_q <= '0;
      end else if (cpu_req && !cpu_we) begin
         case (src)
            SRC_RAM:  rdata_q <= ram_rd;
            SRC_PORT: rdata_q <= port_data;
            default:  rdata_q <= '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) err_q <= 1'b0;
      else if (per_req && multi_claim) err_q <= 1'b1;
   end

   assign cpu_rdata    = rdata_q;
   assign busy         = sweep_busy;
   assign conflict_err = err_q;
endmodule

// File: rtl/bus_dec_chk.sv
module bus_dec_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int WIN_AW = 13,
   parameter int NPORT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hard_rst,
   input logic              soft_rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              busy,
   input logic              conflict_err,
   input logic              per_req,
   input logic              per_we,
   input logic [ADDR_W-1:0] per_addr,
   input logic [NPORT-1:0]  per_claim
);
   logic hi_addr;
   assign hi_addr = (cpu_addr[ADDR_W-1:WIN_AW] != '0);

   AST_RAM_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !hi_addr) |-> !per_req);  // R1
   AST_EXT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && hi_addr && !busy) |-> (per_req && per_addr == cpu_addr && per_we == cpu_we));  // R2
   AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (per_req && !per_we && per_claim == '0 && !soft_rst) |=> (cpu_rdata == '0));  // R4
   AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (per_req && $countones(per_claim) > 1 && !soft_rst) |=> conflict_err);  // R6
   AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict_err && !soft_rst) |=> conflict_err);  // R6
   AST_HARD_STARTS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst |=> busy);  // R7
   AST_SOFT_NO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !hard_rst && !busy) |=> (!busy && !conflict_err));  // R8
   AST_BUSY_BLOCKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !per_req);  // R9
   AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cpu_req && !cpu_we && !soft_rst) |=> (cpu_rdata == '0));  // R9
endmodule

bind cpu_bus_decoder bus_dec_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .NPORT(NPORT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
   .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
   .busy(busy), .conflict_err(conflict_err), .per_req(per_req), .per_we(per_we),
   .per_addr(per_addr), .per_claim(per_claim)
);

// File: tb/sim_cpu_bus_decoder.sv
`timescale 1ns/1ps
module sim_cpu_bus_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, hard_rst = 1'b0, soft_rst = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        busy, conflict_err, per_req, per_we;
   logic [15:0] per_addr;
   logic [7:0]  per_wdata;
   logic [3:0]  per_claim = '0;
   logic [31:0] per_rdata = 32'hA3A2A1A0;

   int n_chk = 0, n_bad = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   int run_len = 0, last_run = 0;

   always #2 clk = ~clk;

   cpu_bus_decoder u0 (
      .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .busy(busy), .conflict_err(conflict_err),
      .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
      .per_claim(per_claim), .per_rdata(per_rdata)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per read strobe
   always @(posedge clk) begin
      if (rst_n && cpu_req && !cpu_we) begin
         #1;
         if (exp_q.size() == 0) chk(1'b0, "scoreboard empty", cpu_rdata, 0);
         else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cpu_rdata === e, t, cpu_rdata, e);
         end
      end
   end

   always @(negedge clk) begin
      if (!rst_n) run_len = 0;
      else if (busy) run_len++;
      else if (run_len != 0) begin
         last_run = run_len;
         run_len = 0;
      end
   end

   task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                         input logic [3:0] claim, input logic [7:0] exp,
                         input string tag, input bit fwd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; per_claim = claim;
      if (!we) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      #1;
      chk(per_req === fwd, {tag, " per_req"}, per_req, fwd);
      if (fwd) begin
         chk(per_addr === a && per_we === we && per_wdata === d,
             {tag, " forwarded fields"}, per_addr, a);
      end
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0; per_claim = '0;
   endtask

   initial begin
      #(4 * 200000);
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b1 && per_req === 1'b0, "R7 reset busy", busy, 1);
      chk(cpu_rdata === 8'h00 && conflict_err === 1'b0, "R6 reset state", cpu_rdata, 0);
      rst_n = 1'b1;
      wait (!busy);
      @(negedge clk);

      access(0, 16'h0000, 0, 0, 8'h00, "R7 power-up zero", 0);
      access(1, 16'h0005, 8'h3C, 0, 0, "R1 write", 0);
      access(0, 16'h0805, 0, 0, 8'h3C, "R1 mirror 1", 0);
      access(0, 16'h1005, 0, 0, 8'h3C, "R1 mirror 2", 0);
      access(0, 16'h1805, 0, 0, 8'h3C, "R1 mirror 3", 0);
      access(1, 16'h1FFF, 8'h77, 0, 0, "R1 top write", 0);
      access(0, 16'h07FF, 0, 0, 8'h77, "R1 top alias", 0);

      access(1, 16'h4016, 8'h55, 4'b0010, 0, "R2 ext write", 1);
      access(0, 16'h0016, 0, 0, 8'h00, "R2 ram untouched", 0);
      access(1, 16'h2005, 8'hEE, 4'b0000, 0, "R5 unclaimed write", 1);
      access(0, 16'h0005, 0, 0, 8'h3C, "R5 ram unchanged", 0);

      access(0, 16'h2002, 0, 4'b0100, 8'hA2, "R10 single claim", 1);
      @(negedge clk);
      chk(cpu_rdata === 8'hA2, "R3 hold", cpu_rdata, 8'hA2);
      access(0, 16'h8000, 0, 4'b0000, 8'h00, "R4 unclaimed read", 1);
      chk(conflict_err === 1'b0, "R6 no conflict yet", conflict_err, 0);

      access(0, 16'hFFF0, 0, 4'b1010, 8'hA1, "R6 lowest port", 1);
      chk(conflict_err === 1'b1, "R6 conflict set", conflict_err, 1);
      @(negedge clk);
      chk(conflict_err === 1'b1, "R6 sticky", conflict_err, 1);

      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk(conflict_err === 1'b0 && busy === 1'b0, "R8 soft clears flag", conflict_err, 0);
      access(0, 16'h0005, 0, 0, 8'h3C, "R8 ram kept", 0);

      hard_rst = 1'b1;
      @(negedge clk);
      hard_rst = 1'b0;
      chk(busy === 1'b1, "R7 sweep started", busy, 1);
      access(0, 16'h0005, 0, 0, 8'h00, "R9 ram read while busy", 0);
      access(0, 16'h3000, 0, 4'b0001, 8'h00, "R9 ext read while busy", 0);
      access(1, 16'h5000, 8'h12, 4'b0001, 0, "R9 ext write while busy", 0);
      wait (!busy);
      @(negedge clk);
      chk(last_run == 2048, "R7 sweep length", last_run, 2048);
      access(0, 16'h0005, 0, 0, 8'h00, "R7 cleared", 0);
      access(0, 16'h07FF, 0, 0, 8'h00, "R7 cleared top", 0);

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule